// File: doc/BRIEF.md
# Program ROM bank address translator

This block turns a CPU window index into a program-ROM bank number. The 32 KB program space above the work area is split into four 8 KB windows. The block returns the bank number for the window being accessed. It also returns a separate bank number for the 8 KB work window that sits below program space. Chip-select decoding and the ROM array are handled outside the block.

Software programs the mapping through a small register write port. There are four 6-bit bank registers, a 3-bit mode register and an outer block field. The mode register chooses the window size: one 32 KB window, two 16 KB halves, or four 8 KB windows. A separate mode variant uses 8 KB windows with each register value bit-reversed. The top mode bit decides where the uppermost window gets its bank. When it is clear, that window is pinned to the last bank of the ROM. When it is set, bank register 3 supplies it.

The outer block field places the whole mapping in one of four 64-bank slices of a larger ROM. Every bank output is computed combinationally from the stored registers and the window index.

Top module: `prg_bank_xlate`

## Requirements
- R1: After reset, all four bank registers hold 0x3F, the mode is 0 and the outer block is 0. With the default ROM size parameter, the outputs then show bank LAST&~3 plus the window index, and the work bank shows 0x3F. LAST is (ROM_BANKS-1)&0x3F.
- R2: Writing address k (0 to 3) loads bank register k with the low 6 bits of the data. The upper data bits are dropped.
- R3: Modes 0 and 4 use 32 KB windows. The base is LAST in mode 0 and register 3 in mode 4. The base has its low 2 bits cleared, and the window index fills those 2 bits.
- R4: Modes 1 and 5 use 16 KB halves. Windows 0 and 1 take register 1 masked to 5 bits. Windows 2 and 3 take LAST in mode 1, or register 3 masked to 5 bits in mode 5. Bit 0 of each base is cleared and replaced by bit 0 of the window index.
- R5: Modes 2 and 6 use 8 KB windows. Window k takes register k, except window 3 takes LAST in mode 2.
- R6: Modes 3 and 7 behave like modes 2 and 6, but each register value is reversed across 6 bits, so bit i moves to bit 5-i. The LAST value used for window 3 in mode 3 is not reversed.
- R7: Writing address 5 sets the outer block from data bits 2:1. The outer block appears at bits 7:6 of both outputs. Writing address 4 sets the mode from data bits 2:0.
- R8: The work bank depends on window size and is then prefixed with the outer block. With 32 KB windows it is ((reg3<<2)+3)&0x3F. With 16 KB windows it is ((reg3<<1)+1)&0x3F. With 8 KB windows it is reg3, reversed in modes 3 and 7.
- R9: A write to address 6 or 7, or any cycle with wr_en low, changes no state.
- R10: The effect of a write is visible on both outputs in the cycle right after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0-3 bank, 4 mode, 5 outer |
| wr_data | input | 8 | Write data |
| win_idx | input | 2 | Index of the 8 KB CPU window being accessed |
| bank_out | output | 8 | Bank number for the addressed window |
| work_bank | output | 8 | Bank number for the work window |

## Verification
The hardest combinations to reach are those where several fields must line up at once. One example is mode 5 with register 3 at or above 32, where the 5-bit mask visibly drops bit 5. Another is mode 3 on window 3, where the fixed last bank must stay unreversed while the other windows reverse. A third is an outer block change in the same run as a reversal. Directed writes set each of these up first. A long random phase then follows, in which mode, outer block, register values and window index all change freely. A behavioural reference model is compared against the outputs on every cycle. The ROM size parameter is set to 48 so that LAST (47) has both low bits set and the alignment is visible.

// File: rtl/prg_bank_xlate.sv
module prg_bank_xlate #(
  parameter int ROM_BANKS = 64,
  parameter int RW = 6,
  parameter int OW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [1:0]    win_idx,
  output logic [RW+OW-1:0] bank_out,
  output logic [RW+OW-1:0] work_bank
);
  localparam int NREG = 4;
  localparam logic [RW-1:0] LAST = RW'((ROM_BANKS - 1) & ((1 << RW) - 1));

  logic [RW-1:0] bank_q [NREG];
  logic [2:0]    mode_q;
  logic [OW-1:0] outer_q;

  function automatic logic [RW-1:0] rev6(input logic [RW-1:0] v);
    for (int i = 0; i < RW; i++) rev6[i] = v[RW-1-i];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank_q[i] <= '1;
      mode_q  <= '0;
      outer_q <= '0;
    end else if (wr_en) begin
      if (!wr_addr[2]) bank_q[wr_addr[1:0]] <= wr_data[RW-1:0];
      else if (wr_addr == 3'd4) mode_q <= wr_data[2:0];
      else if (wr_addr == 3'd5) outer_q <= wr_data[OW:1];
    end
  end

  logic          reg3_top;
  logic [RW-1:0] r3, sel_reg, base32, base16, val8, low;
  logic [RW-1:0] work_low;

  assign reg3_top = mode_q[2];
  assign r3       = bank_q[3];
  assign sel_reg  = bank_q[win_idx];
  assign base32   = reg3_top ? r3 : LAST;
  assign base16   = !win_idx[1] ? {1'b0, bank_q[1][RW-2:0]}
                  : (reg3_top ? {1'b0, r3[RW-2:0]} : LAST);

  always_comb begin
    if (win_idx == 2'd3 && !reg3_top) val8 = LAST;
    else if (mode_q[1:0] == 2'd3)     val8 = rev6(sel_reg);
    else                              val8 = sel_reg;
  end

  always_comb begin
    unique case (mode_q[1:0])
      2'd0:    low = {base32[RW-1:2], win_idx};
      2'd1:    low = {base16[RW-1:1], win_idx[0]};
      default: low = val8;
    endcase
  end

  always_comb begin
    unique case (mode_q[1:0])
      2'd0:    work_low = {r3[RW-3:0], 2'b11};
      2'd1:    work_low = {r3[RW-2:0], 1'b1};
      2'd2:    work_low = r3;
      default: work_low = rev6(r3);
    endcase
  end

  assign bank_out  = {outer_q, low};
  assign work_bank = {outer_q, work_low};

  assert_outer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_addr) == 3'd5)
      |-> (bank_out[7:6] == $past(wr_data[2:1]) && work_bank[7:6] == $past(wr_data[2:1])));

  assert_reg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_addr) == 3'd2 && mode_q == 3'd6 && win_idx == 2'd2)
      |-> bank_out[5:0] == $past(wr_data[5:0]));

  assert_align32_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'd0) |-> bank_out[1:0] == win_idx);

  assert_half16_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'd1 && !win_idx[1]) |-> (bank_out[5] == 1'b0 && bank_out[0] == win_idx[0]));

  assert_work_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'd0) |-> work_bank[1:0] == 2'b11);

  assert_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_addr[2:1] == 2'b11) |=> ($stable(mode_q) && $stable(outer_q) && $stable(r3)));
endmodule

// File: tb/prg_bank_xlate_test.sv
`timescale 1ns/1ps
module prg_bank_xlate_test;
  localparam int ROMB = 48;
  localparam int LASTB = (ROMB - 1) & 63;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] win_idx = 0;
  logic [7:0] bank_out, work_bank;

  int compared = 0, mismatched = 0;
  int m_reg [4];
  int m_mode, m_outer;
  bit done = 0;

  prg_bank_xlate #(.ROM_BANKS(ROMB)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .win_idx(win_idx), .bank_out(bank_out), .work_bank(work_bank));

  always #2.5 clk = ~clk;

  function automatic int rv(int v);
    int r = 0;
    for (int i = 0; i < 6; i++) if ((v >> i) & 1) r += 1 << (5 - i);
    return r;
  endfunction

  function automatic int exp_bank(int w);
    int kind = m_mode % 4, sz, v, full;
    sz = (kind == 0) ? 4 : (kind == 1) ? 2 : 1;
    case (kind)
      0: v = (m_mode >= 4) ? m_reg[3] : LASTB;
      1: v = (w < 2) ? m_reg[1] % 32 : ((m_mode >= 4) ? m_reg[3] % 32 : LASTB);
      2: v = (w == 3 && m_mode < 4) ? LASTB : m_reg[w];
      default: v = (w == 3 && m_mode < 4) ? LASTB : rv(m_reg[w]);
    endcase
    full = m_outer * 64 + v;
    return full - (full % sz) + (w % sz);
  endfunction

  function automatic int exp_work();
    int kind = m_mode % 4, v;
    case (kind)
      0: v = (m_reg[3] * 4 + 3) % 64;
      1: v = (m_reg[3] * 2 + 1) % 64;
      2: v = m_reg[3];
      default: v = rv(m_reg[3]);
    endcase
    return m_outer * 64 + v;
  endfunction

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (mode %0d win %0d)", tag, act, exp, m_mode, win_idx);
    end
  endtask

  task automatic compare_all(string tag);
    string t = tag;
    if (t == "") t = (m_mode % 4 == 0) ? "R3" : (m_mode % 4 == 1) ? "R4" : (m_mode % 4 == 2) ? "R5" : "R6";
    check(t, bank_out, exp_bank(win_idx));
    check((tag == "") ? "R8" : tag, work_bank, exp_work());
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_reg[i] = 63;
    m_mode = 0; m_outer = 0;
  endtask

  task automatic cycle(bit we, int a, int d, int w, string tag);
    @(negedge clk);
    wr_en = we; wr_addr = a[2:0]; wr_data = d[7:0]; win_idx = w[1:0];
    @(posedge clk);
    if (we) begin
      if (a < 4) m_reg[a] = d % 64;
      else if (a == 4) m_mode = d % 8;
      else if (a == 5) m_outer = (d >> 1) % 4;
    end
    #1 compare_all(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    for (int w = 0; w < 4; w++) cycle(0, 0, 0, w, "R1");
    // R1 explicit reset values with ROM_BANKS=48: base 44, work 63
    @(negedge clk); win_idx = 2;
    #1 check("R1", bank_out, 46); check("R1", work_bank, 63);

    // R2 / R10: 6-bit load visible next cycle, mode 6 window 2
    cycle(1, 4, 6, 0, "R7");
    cycle(1, 2, 8'hC5, 2, "R10");
    check("R2", bank_out, 5);
    // R9: ignored addresses and idle strobe
    cycle(1, 6, 8'hFF, 2, "R9");
    cycle(1, 7, 8'h00, 2, "R9");
    cycle(0, 2, 8'h11, 2, "R9");
    check("R9", bank_out, 5);

    // R4: mode 5, reg3 >= 32 loses bit 5
    cycle(1, 3, 8'h2B, 0, "R2");
    cycle(1, 1, 8'h37, 0, "R2");
    cycle(1, 4, 5, 0, "R4");
    for (int w = 0; w < 4; w++) cycle(0, 0, 0, w, "R4");
    cycle(1, 4, 1, 3, "R4");
    check("R4", bank_out, 47);

    // R6: mode 3 window 3 stays unreversed, others reversed; with outer block
    cycle(1, 5, 8'h06, 0, "R7");
    cycle(1, 0, 8'h01, 0, "R6");
    cycle(1, 4, 3, 0, "R6");
    check("R6", bank_out, 192 + 32);
    cycle(0, 0, 0, 3, "R6");
    check("R6", bank_out, 192 + LASTB);
    cycle(1, 4, 7, 3, "R6");
    cycle(1, 4, 0, 1, "R3");
    cycle(1, 4, 4, 2, "R3");
    cycle(1, 4, 2, 3, "R5");
    cycle(1, 5, 8'h02, 1, "R7");
    check("R7", bank_out[7:6], 1);

    // random phase, every cycle compared against the model
    for (int n = 0; n < 20000; n++)
      cycle($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 255),
            $urandom_range(0, 3), "");

    // mid-run reset returns to R1 state
    @(negedge clk) rst_n = 0;
    @(posedge clk); model_reset();
    @(negedge clk) rst_n = 1; win_idx = 1;
    #1 check("R1", bank_out, 45); check("R1", work_bank, 63);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule